// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for each beat of a synchronous DRAM read or write burst. A start strobe loads an 8-bit start column together with a burst-length code and an ordering select, sequential or interleaved. From the next clock onward the block presents one column per cycle with a valid flag. On the final beat of a fixed-length burst it also raises a last-beat flag.

A burst ends in one of three ways. A fixed-length burst ends after its final beat. A stop strobe cuts any burst short. A new start strobe replaces the running burst on any cycle, and start strobes may arrive on consecutive clocks. A full-page burst walks the whole row, wrapping from the top column back to zero, and runs until it is stopped or replaced. The memory array, bank handling and data path sit outside this block.

Top module: `sdram_col_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, beat_vld_o and last_o are low.
- R2: A start strobe sampled at a clock edge makes beat_vld_o high in the following cycle, and col_o equals the sampled start column in that cycle (beat 0).
- R3: In sequential order, each later beat adds one to the low log2(length) bits of the previous column and wraps inside the aligned block of that length. The upper bits keep the start column's value, and one beat is presented per cycle.
- R4: In interleaved order, the low log2(length) bits of beat k equal the start column's low bits XOR k, and the upper bits stay at the start value.
- R5: blen_code_i selects the length. Code 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives a full page. Codes 4, 5 and 6 give a single beat.
- R6: last_o is high exactly on the final beat of a fixed-length burst, and beat_vld_o is low in the next cycle unless a new start was sampled.
- R7: A sequential full-page burst steps through all 256 columns, wraps from 255 to 0, continues without end, and never raises last_o.
- R8: When ilv_i is high with code 7 (full page), which is not a legal interleaved length, the burst runs as a single beat.
- R9: A stop strobe sampled while no start is sampled makes beat_vld_o low from the next cycle on. A stop while idle has no effect on the outputs.
- R10: A start sampled during a running burst replaces it at once: the next cycle shows beat 0 of the new burst. A start sampled together with a stop wins over the stop.
- R11: Start strobes on consecutive clocks each produce their own beat 0 in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a new burst at start_col_i |
| start_col_i | input | COL_W | Start column of the burst |
| blen_code_i | input | 3 | Burst-length code (see R5) |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential |
| stop_i | input | 1 | Terminate the running burst |
| col_o | output | COL_W | Column address of the current beat |
| beat_vld_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Current beat is the final beat of a fixed-length burst |

## Verification
The bench builds the block with the default column width of 8 and with interleaved support enabled. This makes it practical to run a full 256-column page including the wrap, and to exercise every interleave length next to every sequential length. Start columns are chosen so their low bits are not aligned, which makes the wrap inside each block and the XOR pattern visible. Mid-burst restarts, start together with stop, back-to-back starts, stops while idle, the spare length codes and the illegal full-page interleave request are all compared beat by beat against a behavioural model.

// File: rtl/sdram_col_pkg.sv
package sdram_col_pkg;

   localparam int unsigned BLEN_CODE_W = 3;

   // burst-length codes seen on blen_code_i
   localparam logic [BLEN_CODE_W-1:0] BLC_1    = 3'd0;
   localparam logic [BLEN_CODE_W-1:0] BLC_2    = 3'd1;
   localparam logic [BLEN_CODE_W-1:0] BLC_4    = 3'd2;
   localparam logic [BLEN_CODE_W-1:0] BLC_8    = 3'd3;
   localparam logic [BLEN_CODE_W-1:0] BLC_PAGE = 3'd7;

   // longest fixed burst needs this many varying column bits
   localparam int unsigned MAX_FIXED_LG = 3;

endpackage

// File: rtl/sdram_col_blen_dec.sv
module sdram_col_blen_dec
   import sdram_col_pkg::*;
#(
   parameter int unsigned COL_W = 8
)(
   input  logic [BLEN_CODE_W-1:0] code_i,
   input  logic                   ilv_i,
   output logic [COL_W-1:0]       mask_o,
   output logic                   page_o
);

   if (COL_W < MAX_FIXED_LG) begin : g_bad_width
      $error("sdram_col_blen_dec: COL_W must cover an 8-beat burst");
   end

   always_comb begin
      mask_o = '0;
      page_o = 1'b0;
      case (code_i)
         BLC_2:    mask_o = COL_W'(1);
         BLC_4:    mask_o = COL_W'(3);
         BLC_8:    mask_o = COL_W'(7);
         BLC_PAGE: begin
            // a full page has no interleaved form: fall back to one beat
            if (!ilv_i) begin
               mask_o = '1;
               page_o = 1'b1;
            end
         end
         default:  mask_o = '0;
      endcase
   end

endmodule

// File: rtl/sdram_col_addr_gen.sv
module sdram_col_addr_gen #(
   parameter int unsigned COL_W  = 8,
   parameter bit          ILV_EN = 1'b1
)(
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] beat_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             ilv_i,
   output logic [COL_W-1:0] col_o
);

   logic [COL_W-1:0] seq_lo;
   logic [COL_W-1:0] fixed_hi;

   assign fixed_hi = base_i & ~mask_i;
   assign seq_lo   = (base_i + beat_i) & mask_i;

   if (ILV_EN) begin : g_ilv
      logic [COL_W-1:0] ilv_lo;
      assign ilv_lo = (base_i ^ beat_i) & mask_i;
      assign col_o  = fixed_hi | (ilv_i ? ilv_lo : seq_lo);
   end else begin : g_seq_only
      logic unused_ilv;
      assign unused_ilv = ilv_i;
      assign col_o      = fixed_hi | seq_lo;
   end

endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
   import sdram_col_pkg::*;
#(
   parameter int unsigned COL_W  = 8,
   parameter bit          ILV_EN = 1'b1
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_i,
   input  logic [COL_W-1:0]       start_col_i,
   input  logic [BLEN_CODE_W-1:0] blen_code_i,
   input  logic                   ilv_i,
   input  logic                   stop_i,
   output logic [COL_W-1:0]       col_o,
   output logic                   beat_vld_o,
   output logic                   last_o
);

   if (COL_W < MAX_FIXED_LG) begin : g_bad_width
      $error("sdram_col_seq: COL_W too small");
   end

   logic             ilv_req;
   logic [COL_W-1:0] dec_mask;
   logic             dec_page;

   logic             act_q;
   logic [COL_W-1:0] beat_q;
   logic [COL_W-1:0] base_q;
   logic [COL_W-1:0] mask_q;
   logic             page_q;
   logic             ilv_q;
   logic             at_end;

   assign ilv_req = ILV_EN ? ilv_i : 1'b0;

   sdram_col_blen_dec #(.COL_W(COL_W)) u_dec (
      .code_i (blen_code_i),
      .ilv_i  (ilv_req),
      .mask_o (dec_mask),
      .page_o (dec_page)
   );

   sdram_col_addr_gen #(.COL_W(COL_W), .ILV_EN(ILV_EN)) u_gen (
      .base_i (base_q),
      .beat_i (beat_q),
      .mask_i (mask_q),
      .ilv_i  (ilv_q),
      .col_o  (col_o)
   );

   assign at_end = act_q && !page_q && (beat_q == mask_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         beat_q <= '0;
         base_q <= '0;
         mask_q <= '0;
         page_q <= 1'b0;
         ilv_q  <= 1'b0;
      end else if (start_i) begin
         act_q  <= 1'b1;
         beat_q <= '0;
         base_q <= start_col_i;
         mask_q <= dec_mask;
         page_q <= dec_page;
         ilv_q  <= ilv_req;
      end else if (stop_i || at_end) begin
         act_q  <= 1'b0;
      end else if (act_q) begin
         beat_q <= beat_q + COL_W'(1);
      end
   end

   assign beat_vld_o = act_q;
   assign last_o     = at_end;

endmodule

// File: rtl/sdram_col_seq_chk.sv
module sdram_col_seq_chk
   import sdram_col_pkg::*;
#(
   parameter int unsigned COL_W = 8
)(
   input logic                   clk,
   input logic                   rst_n,
   input logic                   start_i,
   input logic [COL_W-1:0]       start_col_i,
   input logic [BLEN_CODE_W-1:0] blen_code_i,
   input logic                   ilv_i,
   input logic                   stop_i,
   input logic [COL_W-1:0]       col_o,
   input logic                   beat_vld_o,
   input logic                   last_o
);

   // R1 / R6: no last flag outside a beat
   a_r6_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> beat_vld_o);

   // R2: beat 0 follows a start and carries the start column
   a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (beat_vld_o && col_o == $past(start_col_i)));

   // R9: stop without start ends the burst
   a_r9_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !start_i) |=> !beat_vld_o);

   // R6: nothing follows the final beat unless restarted
   a_r6_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && !start_i) |=> !beat_vld_o);

   // R3: an unfinished burst keeps going
   a_r3_continues: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_vld_o && !last_o && !start_i && !stop_i) |=> beat_vld_o);

   // R7: a sequential full page never flags its first beat as last
   a_r7_page_no_last: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !ilv_i && blen_code_i == BLC_PAGE) |=> !last_o);

endmodule

bind sdram_col_seq sdram_col_seq_chk #(.COL_W(COL_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .start_col_i (start_col_i),
   .blen_code_i (blen_code_i),
   .ilv_i       (ilv_i),
   .stop_i      (stop_i),
   .col_o       (col_o),
   .beat_vld_o  (beat_vld_o),
   .last_o      (last_o)
);

// File: tb/tb_sdram_col_seq.sv
module tb_sdram_col_seq;

   localparam int COL_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [COL_W-1:0] start_col_i = '0;
   logic [2:0]       blen_code_i = '0;
   logic             ilv_i = 1'b0;
   logic             stop_i = 1'b0;
   logic [COL_W-1:0] col_o;
   logic             beat_vld_o;
   logic             last_o;

   int n_chk = 0;
   int n_bad = 0;
   string phase = "R1";

   always #4 clk = ~clk;

   sdram_col_seq dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
      .blen_code_i(blen_code_i), .ilv_i(ilv_i), .stop_i(stop_i),
      .col_o(col_o), .beat_vld_o(beat_vld_o), .last_o(last_o)
   );

   // behavioural reference
   int m_act = 0, m_k = 0, m_base = 0, m_len = 1, m_page = 0, m_ilv = 0;
   int in_reset = 1;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_act = 0; in_reset = 1;
      end else begin
         in_reset = 0;
         if (start_i) begin
            m_act = 1; m_k = 0; m_base = int'(start_col_i); m_ilv = int'(ilv_i);
            m_page = 0;
            case (blen_code_i)
               3'd1: m_len = 2;
               3'd2: m_len = 4;
               3'd3: m_len = 8;
               3'd7: begin m_len = 256; m_page = ilv_i ? 0 : 1; if (ilv_i) m_len = 1; end
               default: m_len = 1;
            endcase
         end else if (stop_i) begin
            m_act = 0;
         end else if (m_act != 0) begin
            if (m_page == 0 && m_k == m_len - 1) m_act = 0;
            else m_k++;
         end
      end
   end

   function automatic int exp_col();
      int lo, hi;
      if (m_page != 0) return (m_base + m_k) % 256;
      lo = m_base % m_len;
      hi = m_base - lo;
      if (m_ilv != 0) return hi + (lo ^ m_k);
      return hi + ((lo + m_k) % m_len);
   endfunction

   function automatic string tag();
      if (in_reset != 0) return "R1";
      if (m_act == 0) return "R9";
      if (m_k == 0) return "R2";
      if (m_page != 0) return "R7";
      if (m_ilv != 0) return "R4";
      return "R3";
   endfunction

   always @(negedge clk) begin
      int e_vld, e_last;
      e_vld  = m_act;
      e_last = (m_act != 0 && m_page == 0 && m_k == m_len - 1) ? 1 : 0;
      n_chk++;
      if (int'(beat_vld_o) != e_vld) begin
         n_bad++;
         $display("FAIL %s (phase %s) valid: got %0d expected %0d", tag(), phase, beat_vld_o, e_vld);
      end
      n_chk++;
      if (int'(last_o) != e_last) begin
         n_bad++;
         $display("FAIL R6 (phase %s) last: got %0d expected %0d", phase, last_o, e_last);
      end
      if (e_vld != 0) begin
         n_chk++;
         if (int'(col_o) != exp_col()) begin
            n_bad++;
            $display("FAIL %s (phase %s) col: got %0h expected %0h", tag(), phase, col_o, exp_col());
         end
      end
   end

   task automatic drive(input bit s, input int c, input int code, input bit il, input bit st);
      @(negedge clk);
      start_i = s; start_col_i = COL_W'(c); blen_code_i = 3'(code); ilv_i = il; stop_i = st;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0);
   endtask

   task automatic burst(input int c, input int code, input bit il, input int wait_n);
      drive(1, c, code, il, 0);
      idle(wait_n);
   endtask

   initial begin
      phase = "R1"; idle(4);
      rst_n = 1'b1;
      idle(2);
      phase = "R9"; drive(0, 0, 0, 0, 1); idle(3);          // R9 stop while idle
      phase = "R5";                                          // R3/R5/R6 sequential lengths
      for (int code = 0; code < 4; code++) burst(8'h2D, code, 0, 10);
      phase = "R4";                                          // R4 interleaved lengths
      for (int code = 0; code < 4; code++) burst(8'h5B, code, 1, 10);
      phase = "R5"; burst(8'h13, 5, 0, 4); burst(8'h13, 4, 1, 4); burst(8'h13, 6, 0, 4);
      phase = "R8"; burst(8'hC6, 7, 1, 4);
      phase = "R7"; burst(8'hFE, 7, 0, 262);
      drive(0, 0, 0, 0, 1); idle(3);
      phase = "R9"; burst(8'h44, 3, 0, 2); drive(0, 0, 0, 0, 1); idle(4);
      phase = "R10"; burst(8'h81, 3, 1, 3); burst(8'h37, 2, 0, 1);
      drive(1, 8'hA9, 3, 0, 1); idle(10);
      phase = "R11";
      drive(1, 8'h10, 3, 0, 0); drive(1, 8'h22, 2, 1, 0);
      drive(1, 8'h35, 1, 0, 0); drive(1, 8'hF7, 3, 1, 0); idle(10);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 20000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule